// File: doc/BRIEF.md
# Interrupt Status and Enable Register Block

This block holds the interrupt state of a memory controller and exposes it as a handful of word registers. Every hardware event source owns one bit. The event always sets a raw pending bit. If that source was enabled when the event arrived, the event also sets a masked pending bit. A single level interrupt line is high while any masked bit is set. Software acknowledges pending events by writing ones to the status registers. Software turns sources on and off by writing ones to a dedicated enable register or to a dedicated disable register.

Two write ports can update the registers in the same cycle. Because of this, an enable and a disable of the same source can arrive together. In that case the source ends up disabled, and a readback of both enable registers shows a zero for that source. Reads are combinational from a separate read address.

Top module: `irq_status_regs`

## Requirements
- R1: A pulse on `evt_i[i]` sets raw bit i at the next clock edge, whatever the enable state of source i.
- R2: Masked bit i is set by an event on source i only if enable bit i was already 1 in the cycle of the event. An enable written in the same cycle as the event does not count for that event.
- R3: Writing a 1 in bit i of word 2 (enable register) sets enable bit i at the next edge.
- R4: Writing a 1 in bit i of word 3 (disable register) clears enable bit i and masked bit i at the next edge. Raw bit i is left unchanged.
- R5: If bit i is written as 1 to word 2 and to word 3 in the same cycle, enable bit i is 0 after the edge. Reads of both word 2 and word 3 then show bit i as 0.
- R6: Reading word 2 or word 3 returns the enable bits. Zero bits in any write leave the state unchanged.
- R7: Writing a 1 in bit i of word 0 (raw status) or word 1 (masked status) clears raw bit i and masked bit i. If an event on source i arrives in the same cycle, the event wins.
- R8: `irq_o` is 1 exactly when at least one masked bit is set.
- R9: A cycle with `rst` high clears all raw, masked and enable bits, and `irq_o` goes low.
- R10: Word addresses 0 to 3 map to raw, masked, enable and disable. Any address with nonzero bits above bit 1 reads as zero, and writes to it are ignored. Read data carries source i in bit i and is zero above the source bits.
- R11: Writes on port A and port B in the same cycle both take effect. It does not matter which port carries which register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| wa_en | input | 1 | Write strobe, port A |
| wa_addr | input | ADDR_W | Word address, port A |
| wa_data | input | NUM_SRC | Write data, port A, one bit per source |
| wb_en | input | 1 | Write strobe, port B |
| wb_addr | input | ADDR_W | Word address, port B |
| wb_data | input | NUM_SRC | Write data, port B, one bit per source |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read data, zero-extended |
| irq_o | output | 1 | Interrupt request, level |

## Verification
All state changes occur at the clock edge that samples the write or event. The raw, masked and enable bits, and `irq_o`, are due one edge after the stimulus. Read data follows `rd_addr` within the same cycle with no register in between. The bench applies stimulus 1 ns after a rising edge and lets exactly one edge pass. It then steps `rd_addr` through the words needed, 1 ns apart, and samples each one before the next edge. Sweeps cover every combination of prior enable, set and clear for four sources. They also cover prior pending bits, clear data and events arriving together with the clear.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

   localparam int NUM_WR_PORTS = 2;

   typedef enum logic [1:0] {
      WORD_RAW   = 2'd0,
      WORD_MSK   = 2'd1,
      WORD_ENSET = 2'd2,
      WORD_ENCLR = 2'd3
   } irq_word_e;

endpackage

// File: rtl/irq_port_decode.sv
module irq_port_decode
   import irq_regs_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int ADDR_W  = 4
) (
   input  logic               we_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] data_i,
   output logic [NUM_SRC-1:0] set_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] stc_o
);
   logic      in_rng;
   irq_word_e sel;

   generate
      if (ADDR_W > 2) begin : g_wide
         assign in_rng = (addr_i[ADDR_W-1:2] == '0);
      end else begin : g_narrow
         assign in_rng = 1'b1;
      end
   endgenerate

   assign sel = irq_word_e'(addr_i[1:0]);

   always_comb begin
      set_o = '0;
      clr_o = '0;
      stc_o = '0;
      if (we_i && in_rng) begin
         unique case (sel)
            WORD_RAW, WORD_MSK: stc_o = data_i;
            WORD_ENSET:         set_o = data_i;
            WORD_ENCLR:         clr_o = data_i;
            default:            ;
         endcase
      end
   end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] en_q_o,
   output logic [NUM_SRC-1:0] en_d_o
);
   logic [NUM_SRC-1:0] en_q;

   // clear dominates: a same-cycle set and clear leaves the source off
   assign en_d_o = (en_q | set_i) & ~clr_i;
   assign en_q_o = en_q;

   always_ff @(posedge clk) begin
      if (rst) en_q <= '0;
      else     en_q <= en_d_o;
   end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic [NUM_SRC-1:0] stc_i,
   input  logic [NUM_SRC-1:0] en_q_i,
   input  logic [NUM_SRC-1:0] en_d_i,
   output logic [NUM_SRC-1:0] raw_o,
   output logic [NUM_SRC-1:0] msk_o
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
         logic r_q;
         logic m_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               r_q <= 1'b0;
               m_q <= 1'b0;
            end else begin
               r_q <= evt_i[i] | (r_q & ~stc_i[i]);
               m_q <= ((evt_i[i] & en_q_i[i]) | (m_q & ~stc_i[i])) & en_d_i[i];
            end
         end
         assign raw_o[i] = r_q;
         assign msk_o[i] = m_q;
      end
   endgenerate
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
   import irq_regs_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               wa_en,
   input  logic [ADDR_W-1:0]  wa_addr,
   input  logic [NUM_SRC-1:0] wa_data,
   input  logic               wb_en,
   input  logic [ADDR_W-1:0]  wb_addr,
   input  logic [NUM_SRC-1:0] wb_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq_o
);
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must be between 1 and DATA_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [NUM_WR_PORTS-1:0]              we_p;
   logic [NUM_WR_PORTS-1:0][ADDR_W-1:0]  ad_p;
   logic [NUM_WR_PORTS-1:0][NUM_SRC-1:0] dt_p;
   logic [NUM_WR_PORTS-1:0][NUM_SRC-1:0] set_p;
   logic [NUM_WR_PORTS-1:0][NUM_SRC-1:0] clr_p;
   logic [NUM_WR_PORTS-1:0][NUM_SRC-1:0] stc_p;

   assign we_p = {wb_en, wa_en};
   assign ad_p = {wb_addr, wa_addr};
   assign dt_p = {wb_data, wa_data};

   generate
      for (genvar p = 0; p < NUM_WR_PORTS; p++) begin : g_port
         irq_port_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
            .we_i  (we_p[p]),
            .addr_i(ad_p[p]),
            .data_i(dt_p[p]),
            .set_o (set_p[p]),
            .clr_o (clr_p[p]),
            .stc_o (stc_p[p])
         );
      end
   endgenerate

   logic [NUM_SRC-1:0] set_v, clr_v, stc_v;
   always_comb begin
      set_v = '0;
      clr_v = '0;
      stc_v = '0;
      for (int p = 0; p < NUM_WR_PORTS; p++) begin
         set_v = set_v | set_p[p];
         clr_v = clr_v | clr_p[p];
         stc_v = stc_v | stc_p[p];
      end
   end

   logic [NUM_SRC-1:0] en_q, en_d, raw_q, msk_q;

   irq_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v),
      .clr_i (clr_v),
      .en_q_o(en_q),
      .en_d_o(en_d)
   );

   irq_status_bank #(.NUM_SRC(NUM_SRC)) u_st (
      .clk   (clk),
      .rst   (rst),
      .evt_i (evt_i),
      .stc_i (stc_v),
      .en_q_i(en_q),
      .en_d_i(en_d),
      .raw_o (raw_q),
      .msk_o (msk_q)
   );

   assign irq_o = |msk_q;

   logic rd_in_rng;
   generate
      if (ADDR_W > 2) begin : g_rd_wide
         assign rd_in_rng = (rd_addr[ADDR_W-1:2] == '0);
      end else begin : g_rd_narrow
         assign rd_in_rng = 1'b1;
      end
   endgenerate

   logic [NUM_SRC-1:0] rd_bits;
   always_comb begin
      rd_bits = '0;
      if (rd_in_rng) begin
         unique case (irq_word_e'(rd_addr[1:0]))
            WORD_RAW:               rd_bits = raw_q;
            WORD_MSK:               rd_bits = msk_q;
            WORD_ENSET, WORD_ENCLR: rd_bits = en_q;
            default:                rd_bits = '0;
         endcase
      end
      rd_data = DATA_W'(rd_bits);
   end
endmodule

// File: rtl/irq_status_regs_chk.sv
module irq_status_regs_chk #(
   parameter int NUM_SRC = 8
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_SRC-1:0] evt_i,
   input logic [NUM_SRC-1:0] set_v,
   input logic [NUM_SRC-1:0] clr_v,
   input logic [NUM_SRC-1:0] raw_q,
   input logic [NUM_SRC-1:0] msk_q,
   input logic [NUM_SRC-1:0] en_q,
   input logic               irq_o
);
   p_raw_capture_r1: assert property (@(posedge clk) disable iff (rst)
      (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

   p_masked_gate_r2: assert property (@(posedge clk) disable iff (rst)
      (msk_q & ~$past(msk_q) & ~$past(en_q)) == '0);

   p_enable_set_r3: assert property (@(posedge clk) disable iff (rst)
      ((set_v & ~clr_v) != '0) |=>
      ((en_q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

   p_disable_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_v != '0) |=> (((en_q | msk_q) & $past(clr_v)) == '0));

   p_conflict_r5: assert property (@(posedge clk) disable iff (rst)
      ((set_v & clr_v) != '0) |=> ((en_q & $past(set_v & clr_v)) == '0));

   p_masked_subset_r8: assert property (@(posedge clk) disable iff (rst)
      (msk_q & ~(raw_q & en_q)) == '0);

   p_reset_clear_r9: assert property (@(posedge clk)
      rst |=> (raw_q == '0 && en_q == '0 && !irq_o));
endmodule

bind irq_status_regs irq_status_regs_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk  (clk),
   .rst  (rst),
   .evt_i(evt_i),
   .set_v(set_v),
   .clr_v(clr_v),
   .raw_q(raw_q),
   .msk_q(msk_q),
   .en_q (en_q),
   .irq_o(irq_o)
);

// File: tb/sim_irq_status_regs.sv
module sim_irq_status_regs;
   localparam int N  = 4;
   localparam int DW = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  evt = '0;
   logic          wa_en = 1'b0, wb_en = 1'b0;
   logic [AW-1:0] wa_addr = '0, wb_addr = '0, rd_addr = '0;
   logic [N-1:0]  wa_data = '0, wb_data = '0;
   logic [DW-1:0] rd_data;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_status_regs #(.NUM_SRC(N), .DATA_W(DW), .ADDR_W(AW)) u0 (
      .clk(clk), .rst(rst), .evt_i(evt),
      .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one edge passes; strobes and events are single-cycle
   task automatic tick();
      @(posedge clk);
      #1;
      wa_en = 1'b0;
      wb_en = 1'b0;
      evt   = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      rd_addr = AW'(a);
      #1;
      v = 32'(rd_data);
   endtask

   task automatic wa(input int a, input int d);
      wa_en = 1'b1; wa_addr = AW'(a); wa_data = N'(d);
   endtask

   task automatic wb(input int a, input int d);
      wb_en = 1'b1; wb_addr = AW'(a); wb_data = N'(d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R9 reset state
      for (int a = 0; a < 4; a++) begin
         rd(a, v); chk("R9 reset word", v, 0);
      end
      chk("R9 reset irq", 32'(irq), 0);

      // R10 out-of-range writes ignored, reads zero
      wa(4, 15); wb(6, 15); tick();
      for (int a = 0; a < 8; a++) begin
         rd(a, v); chk("R10 alias write", v, 0);
      end
      wa(2, 15); evt = 4'hF; tick();
      evt = 4'hF; tick();
      rd(0, v); chk("R10 raw in range", v, 15);
      for (int a = 4; a < 8; a++) begin
         rd(a, v); chk("R10 high address", v, 0);
      end

      // R9 reset in mid-run
      rst = 1'b1; tick(); rst = 1'b0;
      for (int a = 0; a < 4; a++) begin
         rd(a, v); chk("R9 mid reset word", v, 0);
      end
      chk("R9 mid reset irq", 32'(irq), 0);

      // enable sweep: R3 R4 R5 R6 R11
      for (int e = 0; e < 16; e++) begin
         for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
               int exp_en;
               string tag;
               wa(3, 15); tick();
               wa(2, e);  tick();
               if (e[0]) begin wb(2, s); wa(3, c); end
               else      begin wa(2, s); wb(3, c); end
               tick();
               exp_en = (e | s) & ~c & 15;
               if ((s & c) != 0)      tag = "R5 conflict R11";
               else if (s != 0)       tag = "R3 set R11";
               else if (c != 0)       tag = "R4 clear R11";
               else                   tag = "R6 zero write";
               rd(2, v); chk(tag, v, exp_en);
               rd(3, v); chk("R6 R5 readback clear word", v, exp_en);
            end
         end
      end

      // status sweep: R1 R2 R7 R8 R4
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 16; p++) begin
            for (int w = 0; w < 16; w++) begin
               int q, er, em;
               wa(0, 15); wb(3, 15); tick();
               wa(2, e); evt = N'(p); tick();
               // event in same cycle as enable: masked must stay clear (R2)
               rd(0, v); chk("R1 raw on event", v, p);
               rd(1, v); chk("R2 same-cycle enable", v, 0);
               wa(0, 15); tick();
               evt = N'(p); tick();
               rd(0, v); chk("R1 raw on event", v, p);
               rd(1, v); chk("R2 masked on event", v, p & e);
               chk("R8 irq after event", 32'(irq), 32'((p & e) != 0));
               q = (w + e) & 15;
               wa((w & 1) ? 0 : 1, w); evt = N'(q); tick();
               er = (q | (p & ~w)) & 15;
               em = er & e;
               rd(0, v); chk("R7 raw after clear", v, er);
               rd(1, v); chk("R7 masked after clear", v, em);
               chk("R8 irq after clear", 32'(irq), 32'(em != 0));
               wb(3, e); tick();
               rd(1, v); chk("R4 masked after disable", v, 0);
               rd(0, v); chk("R4 raw kept after disable", v, er);
            end
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule